// File: doc/BRIEF.md
# Dual-Host Pin Bank with Change Interrupt and Wake-Up

This block controls a bank of sixteen general-purpose pins. Software can make each pin an output, which it then drives from a data register, or an input. The bank samples every pin through a synchronizer. When an input pin changes level, the bank records the change in a sticky status register. Each status bit has its own enable bit, and the enabled status bits form one interrupt line.

Two processor hosts reach the same registers through two separate request ports. When both hosts request in the same cycle, the bank serves one of them. The grant alternates between the hosts. The other host sees its ready signal held low and keeps its request up.

A system idle input changes what an enabled pin change does. While idle is high, an enabled change raises a wake-up request and the interrupt line is held low. The wake-up request stays up until idle falls or software clears the enabled status bits.

Top module: `pin_bank_top`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all zero). The registers at offset 0 (direction), offset 1 (output data), offset 3 (enable) and offset 4 (status) read as zero. `irq_o` and `wake_o` are low.
- R2: Bit i of the direction register (offset 0) set to 1 drives `pin_oe[i]` high. `pin_out` always equals the output data register (offset 1). Every pin is configured on its own.
- R3: Reading offset 2 returns the pin levels after a two-stage synchronizer. A level applied to `pin_in` is visible there once two clock edges have passed, and not after one.
- R4: A level change on a pin whose direction bit is 0 sets its bit in the status register (offset 4). The bit stays set. A pin whose direction bit is 1 never sets its status bit.
- R5: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A change on a pin in the same cycle as the clear wins, so that pin's status bit stays set.
- R6: While `idle_i` is low, `irq_o` is high exactly when some status bit and its enable bit (offset 3) are both 1. While `idle_i` is high, `irq_o` is low.
- R7: While `idle_i` is high, an enabled pin change raises `wake_o` and keeps it high. `wake_o` falls one cycle after `idle_i` falls, or one cycle after the last enabled status bit is cleared.
- R8: In any cycle at most one host has ready high. A host that requests alone gets ready high in the same cycle, and its access takes effect at that clock edge.
- R9: When both hosts request in the same cycle, the host that was not granted most recently wins. The loser's ready is low and its access does nothing. If the loser keeps its request, it is granted in the next cycle.
- R10: Offsets 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| idle_i | input | 1 | System idle; high turns enabled pin changes into a wake-up request |
| pin_in | input | 16 | Pin levels sampled from the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables, 1 = drive |
| a_req | input | 1 | Host A access request |
| a_we | input | 1 | Host A write (1) or read (0) |
| a_addr | input | 3 | Host A register offset |
| a_wdata | input | 16 | Host A write data |
| a_rdata | output | 16 | Host A read data, valid when `a_ready` is high |
| a_ready | output | 1 | Host A access is performed this cycle |
| b_req | input | 1 | Host B access request |
| b_we | input | 1 | Host B write (1) or read (0) |
| b_addr | input | 3 | Host B register offset |
| b_wdata | input | 16 | Host B write data |
| b_rdata | output | 16 | Host B read data, valid when `b_ready` is high |
| b_ready | output | 1 | Host B access is performed this cycle |
| irq_o | output | 1 | Active-mode pin-change interrupt |
| wake_o | output | 1 | Idle-mode wake-up request |

## Verification
The hardest case to reach from the ports is a contended access where the losing host keeps its request into the following cycle. Getting there takes both ports driven at the same falling edge and ready sampled on each port in each of three cycles. The bench drives both hosts in that way, notes which host won the first cycle, and changes the winner's write data while its request stays up. This shows on `pin_out`, cycle by cycle, that the loser's write did nothing while it waited, that the loser was served next, and that the original winner finished last. The wake-up release is reached in two separate ways: once by clearing status while idle stays high, and once by dropping idle with status still pending, which also shows the held-back interrupt appearing.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

   // Register offsets
   localparam int OFS_DIR  = 0;
   localparam int OFS_DOUT = 1;
   localparam int OFS_DIN  = 2;
   localparam int OFS_IEN  = 3;
   localparam int OFS_STAT = 4;

   typedef enum logic {
      HOST_A = 1'b0,
      HOST_B = 1'b1
   } host_e;

endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
   parameter int NPINS  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] raw_i,
   output logic [NPINS-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pin_bank_sync: STAGES must be at least 2");
   end

   logic [NPINS-1:0] stg_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pin_bank_arb.sv
module pin_bank_arb #(
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a_req,
   input  logic b_req,
   output logic gnt_a,
   output logic gnt_b
);
   import pin_bank_pkg::*;

   host_e last_q;

   if (ROUND_ROBIN) begin : g_rr
      assign gnt_a = a_req && (!b_req || (last_q == HOST_B));
      assign gnt_b = b_req && !gnt_a;
   end else begin : g_fixed
      assign gnt_a = a_req;
      assign gnt_b = b_req && !a_req;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     last_q <= HOST_B;
      else if (gnt_a) last_q <= HOST_A;
      else if (gnt_b) last_q <= HOST_B;
   end

   // R8
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt_a, gnt_b}));

   // R8
   lone_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && !b_req) |-> gnt_a);

   if (ROUND_ROBIN) begin : g_rr_chk
      // R9
      alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_req && b_req && gnt_a) |=> (b_req |-> gnt_b));
   end

endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs #(
   parameter int NPINS = 16,
   parameter int AW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [NPINS-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr_a,
   input  logic [AW-1:0]    rd_addr_b,
   input  logic [NPINS-1:0] din,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] dout_q,
   output logic [NPINS-1:0] ien_q,
   output logic [NPINS-1:0] stat_q,
   output logic [NPINS-1:0] evt,
   output logic [NPINS-1:0] rdata_a,
   output logic [NPINS-1:0] rdata_b
);
   import pin_bank_pkg::*;

   logic [NPINS-1:0] prev_q;
   logic             wr_dir, wr_dout, wr_ien, wr_stat;
   logic [NPINS-1:0] clr_mask;

   assign wr_dir  = wr_en && (wr_addr == AW'(OFS_DIR));
   assign wr_dout = wr_en && (wr_addr == AW'(OFS_DOUT));
   assign wr_ien  = wr_en && (wr_addr == AW'(OFS_IEN));
   assign wr_stat = wr_en && (wr_addr == AW'(OFS_STAT));

   // change detection on input pins only
   assign evt      = (din ^ prev_q) & ~dir_q;
   assign clr_mask = wr_stat ? wr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         ien_q  <= '0;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= din;
         if (wr_dir)  dir_q  <= wr_data;
         if (wr_dout) dout_q <= wr_data;
         if (wr_ien)  ien_q  <= wr_data;
         stat_q <= (stat_q & ~clr_mask) | evt;
      end
   end

   function automatic logic [NPINS-1:0] read_mux(input logic [AW-1:0] ofs);
      if      (ofs == AW'(OFS_DIR))  return dir_q;
      else if (ofs == AW'(OFS_DOUT)) return dout_q;
      else if (ofs == AW'(OFS_DIN))  return din;
      else if (ofs == AW'(OFS_IEN))  return ien_q;
      else if (ofs == AW'(OFS_STAT)) return stat_q;
      else                           return '0;
   endfunction

   assign rdata_a = read_mux(rd_addr_a);
   assign rdata_b = read_mux(rd_addr_b);

   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R4
   out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));

   // R5
   sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && |($past(stat_q) & ~stat_q)) |-> $past(wr_stat));

endmodule

// File: rtl/pin_bank_notify.sv
module pin_bank_notify #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_i,
   input  logic [NPINS-1:0] evt,
   input  logic [NPINS-1:0] ien_q,
   input  logic [NPINS-1:0] stat_q,
   output logic             irq_o,
   output logic             wake_o
);

   logic pending;
   logic wake_q;

   assign pending = |(stat_q & ien_q);
   assign irq_o   = pending && !idle_i;

   always_ff @(posedge clk) begin
      if (!rst_n)              wake_q <= 1'b0;
      else if (!idle_i)        wake_q <= 1'b0;
      else if (|(evt & ien_q)) wake_q <= 1'b1;
      else if (!pending)       wake_q <= 1'b0;
   end

   assign wake_o = wake_q;

   // R7
   wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> !wake_o);

   // R7
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && idle_i && pending) |=> wake_o);

endmodule

// File: rtl/pin_bank_top.sv
module pin_bank_top #(
   parameter int NPINS       = 16,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_i,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   input  logic             a_req,
   input  logic             a_we,
   input  logic [AW-1:0]    a_addr,
   input  logic [NPINS-1:0] a_wdata,
   output logic [NPINS-1:0] a_rdata,
   output logic             a_ready,
   input  logic             b_req,
   input  logic             b_we,
   input  logic [AW-1:0]    b_addr,
   input  logic [NPINS-1:0] b_wdata,
   output logic [NPINS-1:0] b_rdata,
   output logic             b_ready,
   output logic             irq_o,
   output logic             wake_o
);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("pin_bank_top: NPINS must be 1..32");
   end
   if (AW < 3) begin : g_bad_aw
      $error("pin_bank_top: AW must be at least 3");
   end

   logic             gnt_a, gnt_b;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [NPINS-1:0] wr_data;
   logic [NPINS-1:0] din, evt;
   logic [NPINS-1:0] dir_q, dout_q, ien_q, stat_q;

   pin_bank_arb #(.ROUND_ROBIN(ROUND_ROBIN)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .a_req (a_req),
      .b_req (b_req),
      .gnt_a (gnt_a),
      .gnt_b (gnt_b)
   );

   assign wr_en   = (gnt_a && a_we) || (gnt_b && b_we);
   assign wr_addr = gnt_b ? b_addr  : a_addr;
   assign wr_data = gnt_b ? b_wdata : a_wdata;

   pin_bank_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_in),
      .sync_o (din)
   );

   pin_bank_regs #(.NPINS(NPINS), .AW(AW)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (a_addr),
      .rd_addr_b (b_addr),
      .din       (din),
      .dir_q     (dir_q),
      .dout_q    (dout_q),
      .ien_q     (ien_q),
      .stat_q    (stat_q),
      .evt       (evt),
      .rdata_a   (a_rdata),
      .rdata_b   (b_rdata)
   );

   pin_bank_notify #(.NPINS(NPINS)) notify_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .idle_i (idle_i),
      .evt    (evt),
      .ien_q  (ien_q),
      .stat_q (stat_q),
      .irq_o  (irq_o),
      .wake_o (wake_o)
   );

   assign a_ready = gnt_a;
   assign b_ready = gnt_b;
   assign pin_out = dout_q;
   assign pin_oe  = dir_q;

endmodule

// File: tb/pin_bank_tb.sv
module pin_bank_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        idle_i;
   logic [15:0] pin_in;
   logic [15:0] pin_out, pin_oe;
   logic        a_req, a_we, b_req, b_we;
   logic [2:0]  a_addr, b_addr;
   logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
   logic        a_ready, b_ready, irq_o, wake_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pin_bank_top dut_i (
      .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe),
      .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_ready(a_ready),
      .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_ready(b_ready),
      .irq_o(irq_o), .wake_o(wake_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one access on one host; returns at a falling edge with the request dropped
   task automatic acc(input bit hb, input bit we, input logic [2:0] ad,
                      input logic [15:0] wd, output logic [15:0] rd);
      @(negedge clk);
      if (hb) begin b_req = 1; b_we = we; b_addr = ad; b_wdata = wd; end
      else    begin a_req = 1; a_we = we; a_addr = ad; a_wdata = wd; end
      #1;
      while (!(hb ? b_ready : a_ready)) begin
         @(negedge clk); #1;
      end
      rd = hb ? b_rdata : a_rdata;
      @(negedge clk);
      if (hb) b_req = 0; else a_req = 0;
   endtask

   task automatic wr(input bit hb, input logic [2:0] ad, input logic [15:0] wd);
      logic [15:0] dummy;
      acc(hb, 1'b1, ad, wd, dummy);
   endtask

   task automatic rd(input bit hb, input logic [2:0] ad, output logic [15:0] v);
      acc(hb, 1'b0, ad, 16'h0, v);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      check("R1 pin_oe", pin_oe, 16'h0);
      check("R1 irq_o", irq_o, 1'b0);
      check("R1 wake_o", wake_o, 1'b0);
      rd(0, 3'd0, v); check("R1 dir", v, 16'h0);
      rd(0, 3'd1, v); check("R1 dout", v, 16'h0);
      rd(1, 3'd3, v); check("R1 ien", v, 16'h0);
      rd(1, 3'd4, v); check("R1 stat", v, 16'h0);
   endtask

   task automatic t_dir_out();
      logic [15:0] v;
      wr(0, 3'd0, 16'h00F0);
      wr(1, 3'd1, 16'h1234);
      check("R2 pin_oe", pin_oe, 16'h00F0);
      check("R2 pin_out", pin_out, 16'h1234);
      rd(1, 3'd0, v); check("R2 dir readback", v, 16'h00F0);
      wr(0, 3'd0, 16'h0000);
      check("R2 pin_oe cleared", pin_oe, 16'h0);
   endtask

   task automatic t_din();
      logic [15:0] v;
      pin_in = 16'hA50F;
      rd(0, 3'd2, v);            // one edge passed at sample
      check("R3 din after one edge", v, 16'h0000);
      settle(2);
      rd(0, 3'd2, v);
      check("R3 din synchronized", v, 16'hA50F);
      wr(0, 3'd4, 16'hFFFF);
   endtask

   task automatic t_change_irq();
      logic [15:0] v;
      wr(0, 3'd3, 16'h0004);
      pin_in[2] = ~pin_in[2];
      settle(4);
      check("R6 irq on enabled change", irq_o, 1'b1);
      pin_in[7] = ~pin_in[7];
      settle(4);
      rd(1, 3'd4, v); check("R4 stat sticky", v, 16'h0084);
      wr(1, 3'd4, 16'h0000);
      rd(1, 3'd4, v); check("R5 write zero keeps", v, 16'h0084);
      wr(0, 3'd4, 16'h0004);
      rd(0, 3'd4, v); check("R5 w1c clears bit", v, 16'h0080);
      check("R6 irq low after clear", irq_o, 1'b0);
      wr(0, 3'd4, 16'hFFFF);
   endtask

   task automatic t_out_ignored();
      logic [15:0] v;
      wr(0, 3'd0, 16'h0020);
      wr(0, 3'd3, 16'hFFFF);
      pin_in[5] = ~pin_in[5];
      settle(5);
      rd(0, 3'd4, v); check("R4 output pin no status", v, 16'h0000);
      check("R4 output pin no irq", irq_o, 1'b0);
      wr(0, 3'd0, 16'h0000);
   endtask

   task automatic t_idle_wake();
      logic [15:0] v;
      wr(0, 3'd4, 16'hFFFF);
      wr(0, 3'd3, 16'h0008);
      idle_i = 1;
      pin_in[3] = ~pin_in[3];
      settle(5);
      check("R7 wake raised", wake_o, 1'b1);
      check("R6 irq held in idle", irq_o, 1'b0);
      settle(10);
      check("R7 wake held", wake_o, 1'b1);
      wr(1, 3'd4, 16'h0008);
      settle(1);
      check("R7 wake cleared by status", wake_o, 1'b0);
      pin_in[3] = ~pin_in[3];
      settle(5);
      check("R7 wake raised again", wake_o, 1'b1);
      idle_i = 0;
      #1;
      check("R6 irq appears when active", irq_o, 1'b1);
      settle(1);
      check("R7 wake drops after idle", wake_o, 1'b0);
      wr(0, 3'd4, 16'hFFFF);
      wr(0, 3'd3, 16'h0000);
   endtask

   task automatic t_arb_lone();
      @(negedge clk);
      b_req = 1; b_we = 0; b_addr = 3'd0;
      #1;
      check("R8 lone b ready", b_ready, 1'b1);
      check("R8 lone a not ready", a_ready, 1'b0);
      @(negedge clk);
      b_req = 0;
   endtask

   task automatic t_arb_contend();
      bit wa;
      wr(0, 3'd0, 16'hFFFF);
      @(negedge clk);
      a_req = 1; a_we = 1; a_addr = 3'd1; a_wdata = 16'h1111;
      b_req = 1; b_we = 1; b_addr = 3'd1; b_wdata = 16'h2222;
      #1;
      check("R8 one ready in conflict", 32'(a_ready) + 32'(b_ready), 32'd1);
      wa = a_ready;
      @(negedge clk);
      check("R9 winner write only", pin_out, wa ? 16'h1111 : 16'h2222);
      if (wa) a_wdata = 16'h3333; else b_wdata = 16'h3333;
      #1;
      check("R9 loser granted next", wa ? b_ready : a_ready, 1'b1);
      check("R9 winner waits", wa ? a_ready : b_ready, 1'b0);
      @(negedge clk);
      check("R9 loser write lands", pin_out, wa ? 16'h2222 : 16'h1111);
      if (wa) b_req = 0; else a_req = 0;
      #1;
      check("R9 winner served last", wa ? a_ready : b_ready, 1'b1);
      @(negedge clk);
      a_req = 0; b_req = 0;
      check("R9 final data", pin_out, 16'h3333);
      wr(0, 3'd0, 16'h0000);
   endtask

   task automatic t_unmapped();
      logic [15:0] v;
      wr(0, 3'd0, 16'h0F0F);
      wr(1, 3'd6, 16'hFFFF);
      rd(1, 3'd6, v); check("R10 unmapped reads zero", v, 16'h0000);
      rd(0, 3'd0, v); check("R10 dir untouched", v, 16'h0F0F);
      rd(0, 3'd3, v); check("R10 ien untouched", v, 16'h0000);
      wr(0, 3'd0, 16'h0000);
   endtask

   initial begin
      rst_n = 0; idle_i = 0; pin_in = '0;
      a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0;
      b_req = 0; b_we = 0; b_addr = '0; b_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_dir_out();
      t_din();
      t_change_irq();
      t_out_ignored();
      t_idle_wake();
      t_arb_lone();
      t_arb_contend();
      t_unmapped();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule